// File: doc/BRIEF.md
# Programmable 24-bit Interval Timer

A byte-addressed interval timer for a CPU-side peripheral bus. Software sets a 24-bit start value through three byte registers and sets the mode through a control register. The counter then steps once on each cycle that the external tick strobe is high. The strobe comes from a prescaler or an edge detector outside this block. The source it selects is published on `clk_sel_o`.

The counter can count down or up and stops at zero. When it reaches zero, the timer expires. Expiry sets a sticky flag and inverts two output bits. If auto-reload is on, the counter restarts from the stored start value. An interrupt line stays high while the flag and the interrupt enable are both set. A read of the status register acknowledges the interrupt. A reload can also be forced from the control register, which also issues a one-cycle reset strobe to the external prescaler.

Top module: `interval_timer`

## Requirements
- R1: After reset the counter, the stored reload value, all control bits and the flag are zero. `irq_o`, `toggle_o`, `aux_o`, `prescale_rst_o` and `clk_sel_o` are all low.
- R2: Writes to addresses 0, 1 and 2 store bits 7:0, 15:8 and 23:16 of the reload value. Reads of those addresses return the matching bytes of the live count on `rdata_o` in the same cycle. Neither a reload-value write nor such a read changes the count.
- R3: A write to address 3 sets the control fields from the following bits. Bits 1:0 drive `clk_sel_o`, bit 2 drives `aux_o` and bit 3 drives `toggle_o`. Bit 4 sets the direction (0 = down, 1 = up), bit 5 enables auto-reload and bit 7 enables the interrupt. All of these take effect from the clock edge of the write.
- R4: A write to address 3 with bit 6 set loads the counter from the reload value at that edge, even if a tick arrives in the same cycle. `prescale_rst_o` is then high for exactly the one following cycle. Bit 6 is not stored, so a later control write with bit 6 clear neither reloads nor pulses.
- R5: On each cycle with `tick_i` high and a non-zero count, the count moves by one in the selected direction, modulo 2^24. A count of zero does not move. Without a tick, the count holds.
- R6: A tick that brings the count to zero is an expiry and sets the flag. With auto-reload enabled, the counter takes the reload value instead of zero.
- R7: Every expiry inverts both `toggle_o` and `aux_o`.
- R8: `irq_o` is high exactly while the flag and the interrupt-enable bit are both 1. It follows a change of either bit from the next edge.
- R9: A read of address 3 returns the interrupt enable in bit 7, the flag in bit 0 and zeros in bits 6:1. The read clears the flag at its edge.
- R10: If an expiry and a status read fall in the same cycle, the flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count-enable strobe from the external tick source |
| addr_i | input | 2 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request, level |
| toggle_o | output | 1 | Output line level, inverted on each expiry |
| aux_o | output | 1 | Spare latched bit, inverted on each expiry |
| clk_sel_o | output | 2 | Selected tick source for the external prescaler |
| prescale_rst_o | output | 1 | One-cycle prescaler reset after a forced reload |

## Verification
Every register update, counter step, flag change and output toggle lands on the clock edge that samples the stimulus. The bench therefore drives on the falling edge and samples on the next falling edge, after exactly one rising edge has passed. `rdata_o` is combinational, so a read is sampled 1 ns after the read strobe is driven, before the edge that clears the flag. `prescale_rst_o` is checked on the first falling edge after the control write, where it must be high, and again one cycle later, where it must be low. Same-cycle collisions are driven within a single cycle: tick with forced reload, and expiry with status read.

// File: rtl/timer_pkg.sv
package timer_pkg;
  // control byte layout, MSB first (bit 7 .. bit 0)
  typedef struct packed {
    logic       irq_en;
    logic       reload;
    logic       auto_rld;
    logic       dir_up;
    logic       pin;
    logic       aux;
    logic [1:0] clk_sel;
  } ctrl_t;
endpackage

// File: rtl/timer_counter.sv
module timer_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             dir_up_i,
  input  logic             auto_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q, step;
  logic             active;

  assign step     = dir_up_i ? count_q + CNT_W'(1) : count_q - CNT_W'(1);
  assign active   = tick_i && !load_i && (count_q != '0);
  assign expire_o = active && (step == '0);
  assign count_o  = count_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              count_q <= '0;
    else if (load_i)          count_q <= reload_i;
    else if (expire_o)        count_q <= auto_i ? reload_i : '0;
    else if (active)          count_q <= step;
  end
endmodule

// File: rtl/timer_flag.sv
module timer_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q;

  // expiry wins over acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (expire_i) flag_q <= 1'b1;
    else if (clr_i)    flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & irq_en_i;
endmodule

// File: rtl/timer_regs.sv
module timer_regs
  import timer_pkg::*;
#(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  input  logic              expire_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  reload_o,
  output ctrl_t             ctrl_o,
  output logic              load_o,
  output logic              stat_rd_o,
  output logic              prescale_rst_o
);
  localparam int unsigned NBYTES = CNT_W / DATA_W;
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBYTES);

  logic [CNT_W-1:0] reload_q;
  ctrl_t            ctrl_q, ctrl_wr;
  logic             ctrl_we, pre_q;
  logic             unused_reload;

  assign ctrl_we   = wr_i && (addr_i == STAT_ADDR);
  assign ctrl_wr   = ctrl_t'(wdata_i[7:0]);
  assign load_o    = ctrl_we && ctrl_wr.reload;
  assign stat_rd_o = rd_i && (addr_i == STAT_ADDR);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        reload_q[b*DATA_W +: DATA_W] <= '0;
      else if (wr_i && (addr_i == ADDR_W'(b)))
        reload_q[b*DATA_W +: DATA_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q        <= ctrl_wr;
      ctrl_q.reload <= 1'b0;  // trigger only, never held
    end else if (expire_i) begin
      ctrl_q.pin <= ~ctrl_q.pin;
      ctrl_q.aux <= ~ctrl_q.aux;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= 1'b0;
    else         pre_q <= load_o;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_ADDR) begin
      rdata_o[DATA_W-1] = ctrl_q.irq_en;
      rdata_o[0]        = flag_i;
    end else begin
      for (int b = 0; b < NBYTES; b++)
        if (addr_i == ADDR_W'(b)) rdata_o = count_i[b*DATA_W +: DATA_W];
    end
  end

  assign unused_reload  = ctrl_q.reload;
  assign reload_o       = reload_q;
  assign ctrl_o         = ctrl_q;
  assign prescale_rst_o = pre_q;
endmodule

// File: rtl/interval_timer.sv
module interval_timer
  import timer_pkg::*;
#(
  parameter  int unsigned CNT_W  = 24,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = $clog2(CNT_W / DATA_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              toggle_o,
  output logic              aux_o,
  output logic [1:0]        clk_sel_o,
  output logic              prescale_rst_o
);
  logic [CNT_W-1:0] count, reload;
  ctrl_t            ctrl;
  logic             load, expire, stat_rd, flag;

  timer_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .rd_i, .wdata_i,
    .count_i(count), .flag_i(flag), .expire_i(expire),
    .rdata_o, .reload_o(reload), .ctrl_o(ctrl), .load_o(load),
    .stat_rd_o(stat_rd), .prescale_rst_o
  );

  timer_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .tick_i,
    .dir_up_i(ctrl.dir_up), .auto_i(ctrl.auto_rld), .load_i(load),
    .reload_i(reload), .count_o(count), .expire_o(expire)
  );

  timer_flag u_flag (
    .clk_i, .rst_ni, .expire_i(expire), .clr_i(stat_rd),
    .irq_en_i(ctrl.irq_en), .flag_o(flag), .irq_o
  );

  assign toggle_o  = ctrl.pin;
  assign aux_o     = ctrl.aux;
  assign clk_sel_o = ctrl.clk_sel;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              irq_o,
  input logic              toggle_o,
  input logic              prescale_rst_o,
  input logic [CNT_W-1:0]  count_i,
  input logic              flag_i,
  input logic              irq_en_i
);
  localparam logic [ADDR_W-1:0] STAT = ADDR_W'(CNT_W / DATA_W);
  logic ctrl_wr, ld_wr, stat_rd;
  assign ctrl_wr = wr_i && (addr_i == STAT);
  assign ld_wr   = ctrl_wr && wdata_i[6];
  assign stat_rd = rd_i && (addr_i == STAT);

  // R4
  prescale_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prescale_rst_o |-> $past(ld_wr));

  // R5
  hold_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_wr) |=> $stable(count_i));

  // R5
  zero_stays_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_i == '0 && !ld_wr) |=> (count_i == '0));

  // R7
  toggle_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_wr ##1 (toggle_o != $past(toggle_o))) |-> flag_i);

  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && flag_i));

  // R9
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && !tick_i) |=> !irq_o);
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i, .rst_ni, .tick_i, .addr_i, .wr_i, .rd_i, .wdata_i,
  .irq_o, .toggle_o, .prescale_rst_o,
  .count_i(count), .flag_i(flag), .irq_en_i(ctrl.irq_en)
);

// File: tb/test_interval_timer.sv
`timescale 1ns/1ps
module test_interval_timer;
  logic       clk_i = 1'b0, rst_ni = 1'b0, tick_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       irq_o, toggle_o, aux_o, prescale_rst_o;
  logic [1:0] clk_sel_o;

  int n_chk = 0, n_fail = 0;

  interval_timer i_interval_timer (
    .clk_i, .rst_ni, .tick_i, .addr_i, .wr_i, .rd_i, .wdata_i,
    .rdata_o, .irq_o, .toggle_o, .aux_o, .clk_sel_o, .prescale_rst_o
  );

  always #10 clk_i = ~clk_i;

  typedef struct packed {
    logic [23:0] rld;
    logic        up;
    logic        auto_r;
    logic [7:0]  n;
    logic [23:0] cnt;
    logic        flag;
    logic        pin;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{24'h000005, 1'b0, 1'b0, 8'd3, 24'h000002, 1'b0, 1'b0},
    '{24'h000005, 1'b0, 1'b0, 8'd5, 24'h000000, 1'b1, 1'b1},
    '{24'h000005, 1'b0, 1'b0, 8'd8, 24'h000000, 1'b1, 1'b1},
    '{24'h000003, 1'b0, 1'b1, 8'd4, 24'h000002, 1'b1, 1'b1},
    '{24'hFFFFFE, 1'b1, 1'b0, 8'd1, 24'hFFFFFF, 1'b0, 1'b0},
    '{24'hFFFFFE, 1'b1, 1'b0, 8'd2, 24'h000000, 1'b1, 1'b1},
    '{24'hFFFFFD, 1'b1, 1'b1, 8'd3, 24'hFFFFFD, 1'b1, 1'b1},
    '{24'h010000, 1'b0, 1'b0, 8'd1, 24'h00FFFF, 1'b0, 1'b0},
    '{24'h000000, 1'b0, 1'b1, 8'd4, 24'h000000, 1'b0, 1'b0}
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic rd_cnt(output logic [23:0] c);
    logic [7:0] b0, b1, b2;
    rd(2'd0, b0); rd(2'd1, b1); rd(2'd2, b2);
    c = {b2, b1, b0};
  endtask

  task automatic ticks(input int n);
    @(negedge clk_i); tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  task automatic load_rld(input logic [23:0] v);
    wr(2'd0, v[7:0]); wr(2'd1, v[15:8]); wr(2'd2, v[23:16]);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  d;
    logic [23:0] c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk({irq_o, toggle_o, aux_o, prescale_rst_o, clk_sel_o}, 0, "R1 outputs");
    rd_cnt(c); chk(c, 0, "R1 count");
    rd(2'd3, d); chk(d, 0, "R1 status");
    wr(2'd3, 8'h40); rd_cnt(c); chk(c, 0, "R1 reload value");

    // R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) begin
      load_rld(VECS[i].rld);
      wr(2'd3, {2'b01, VECS[i].auto_r, VECS[i].up, 4'b0000});
      rd(2'd3, d);
      if (VECS[i].n != 0) ticks(int'(VECS[i].n));
      rd_cnt(c);
      chk(c, VECS[i].cnt, $sformatf("R5/R6 count vec %0d", i));
      chk(toggle_o, VECS[i].pin, $sformatf("R7 toggle vec %0d", i));
      chk(aux_o, VECS[i].pin, $sformatf("R7 aux vec %0d", i));
      rd(2'd3, d);
      chk(d, {7'b0, VECS[i].flag}, $sformatf("R6 flag vec %0d", i));
    end

    // R3 control fields
    wr(2'd3, 8'h0F);
    chk({clk_sel_o, aux_o, toggle_o}, 4'b1111, "R3 fields");
    wr(2'd3, 8'h01);
    chk({clk_sel_o, aux_o, toggle_o}, 4'b0100, "R3 fields clear");

    // R4 prescaler pulse and trigger not held
    load_rld(24'h000010);
    @(negedge clk_i); addr_i = 2'd3; wdata_i = 8'h40; wr_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0; tick_i = 1'b0;
    chk(prescale_rst_o, 1, "R4 pulse high");
    @(negedge clk_i);
    chk(prescale_rst_o, 0, "R4 pulse one cycle");
    rd_cnt(c); chk(c, 24'h10, "R4 reload over tick");
    // R2 reload write leaves count
    wr(2'd0, 8'h55);
    rd_cnt(c); chk(c, 24'h10, "R2 count untouched");
    wr(2'd3, 8'h00);
    chk(prescale_rst_o, 0, "R4 no pulse when bit6 clear");
    rd_cnt(c); chk(c, 24'h10, "R4 no reload when bit6 clear");
    wr(2'd3, 8'h40);
    rd_cnt(c); chk(c, 24'h55, "R2 low byte stored");

    // R8 R9 interrupt and acknowledge
    load_rld(24'h000001);
    wr(2'd3, 8'hC0); rd(2'd3, d);
    chk(irq_o, 0, "R8 idle");
    ticks(1);
    chk(irq_o, 1, "R8 irq after expiry");
    rd(2'd3, d); chk(d, 8'h81, "R9 status bits");
    chk(irq_o, 0, "R9 ack drops irq");
    rd(2'd3, d); chk(d, 8'h80, "R9 flag cleared");
    wr(2'd3, 8'h40); ticks(1);
    chk(irq_o, 0, "R8 masked");
    wr(2'd3, 8'h80);
    chk(irq_o, 1, "R8 enable with flag set");
    rd(2'd3, d);

    // R10 expiry collides with acknowledge
    load_rld(24'h000002);
    wr(2'd3, 8'h40); rd(2'd3, d); ticks(1);
    @(negedge clk_i); addr_i = 2'd3; rd_i = 1'b1; tick_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0; tick_i = 1'b0;
    rd(2'd3, d); chk(d, 8'h01, "R10 flag kept");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule